// File: doc/BRIEF.md
# Cascaded Decade Poll Monitor

This block keeps four chained counters that advance on a periodic poll strobe. It is meant to sit beside an error-reporting unit as a sample or self-test monitor. Each pulse of the strobe is one poll. The lowest stage counts polls. Each higher stage counts the boundaries of the stage below it: every tenth, hundredth and thousandth poll.

When a higher stage steps, the stage directly beneath it returns to zero in the same clock edge. The lower three stages therefore always read 0 to 9, and the top stage counts thousands of polls. A separate internal divide chain measures the poll boundaries. A synchronous clear empties both that chain and all four stages, so counting restarts from zero. Generating the poll period lies outside this block.

Top module: `decade_poll_monitor`

## Requirements
- R1: While rst_ni is low, all four stage outputs read zero, and they stay zero until the first accepted poll.
- R2: Each clock edge with poll_i high and clear_i low raises stage0_o by one, unless a decade boundary applies. An edge with both inputs low changes no output.
- R3: On every 10th accepted poll, counted from reset or from the last clear, stage1_o rises by one and stage0_o becomes zero at that same edge.
- R4: On every 100th accepted poll, stage2_o rises by one and stage1_o becomes zero at that same edge. stage0_o is also zero.
- R5: On every 1000th accepted poll, stage3_o rises by one and stage2_o becomes zero at that same edge. stage0_o and stage1_o are also zero.
- R6: stage3_o is TOP_W bits wide (16 by default) and holds at its all-ones value once it gets there. The lower stages keep cycling through 0 to 9 while it holds.
- R7: An edge with clear_i high sets all four stages to zero. It also restarts the boundary count, so the next stage1_o step comes on the 10th accepted poll after the clear.
- R8: When clear_i and poll_i are high at the same edge, the clear wins: every stage reads zero afterwards and that poll is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poll_i | input | 1 | One-cycle poll strobe |
| clear_i | input | 1 | Synchronous clear of all stages and the boundary count |
| stage0_o | output | $clog2(RATIO) | Poll count within the current decade, 0 to 9 |
| stage1_o | output | $clog2(RATIO) | Decade count, 0 to 9 |
| stage2_o | output | $clog2(RATIO) | Hundreds count, 0 to 9 |
| stage3_o | output | TOP_W | Thousands count, saturating |

## Verification
The bench targets the edges where two or three stages change together: the 10th, 100th and 1000th polls. A design that ordered the clear and the increment wrongly would show 10 on a lower stage, or leave a stale digit after a boundary. Clears are applied in the middle of a decade, including one on the same edge as a poll. This catches a boundary counter that is not restarted (the next rollover comes early) and a poll that slips through the clear. The top stage is run past its maximum with a narrowed width, so a design that wrapped it back to zero would be caught.

// File: rtl/decade_poll_pkg.sv
package decade_poll_pkg;
  localparam int unsigned DEF_RATIO  = 10;
  localparam int unsigned DEF_TOP_W  = 16;
  localparam int unsigned NUM_LEVELS = 3;
endpackage

// File: rtl/poll_prescaler.sv
// Chain of mod-RATIO counters; wrap_o[k] marks every RATIO^(k+1)-th accepted poll.
module poll_prescaler #(
  parameter int unsigned RATIO  = 10,
  parameter int unsigned LEVELS = 3,
  localparam int unsigned CW    = $clog2(RATIO)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              poll_i,
  input  logic              clear_i,
  output logic [LEVELS-1:0] wrap_o
);
  logic [LEVELS:0] tick;
  assign tick[0] = poll_i & ~clear_i;

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    logic [CW-1:0] cnt_q;
    assign wrap_o[k]  = tick[k] && (cnt_q == CW'(RATIO - 1));
    assign tick[k+1]  = wrap_o[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cnt_q <= '0;
      else if (clear_i)      cnt_q <= '0;
      else if (wrap_o[k])    cnt_q <= '0;
      else if (tick[k])      cnt_q <= cnt_q + 1'b1;
    end

    a_r3_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q < CW'(RATIO));
    a_r7_cnt_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> cnt_q == '0);
    if (k > 0) begin : g_nest
      a_r4_wrap_nested: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o[k] |-> wrap_o[k-1]);
    end
  end
endmodule

// File: rtl/poll_stage.sv
// One counter stage: clear beats increment; optional saturation at all-ones.
module poll_stage #(
  parameter int unsigned W   = 4,
  parameter bit          SAT = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] val_o
);
  logic at_max;
  assign at_max = SAT && (val_o == {W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              val_o <= '0;
    else if (clr_i)           val_o <= '0;
    else if (inc_i && !at_max) val_o <= val_o + 1'b1;
  end

  a_r7_stage_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> val_o == '0);
  a_r2_stage_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && val_o != {W{1'b1}}) |=> val_o == W'($past(val_o) + 1'b1));
  a_r2_stage_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(val_o));
  if (SAT) begin : g_sat
    a_r6_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i && !clr_i && val_o == {W{1'b1}}) |=> val_o == {W{1'b1}});
  end
endmodule

// File: rtl/decade_poll_monitor.sv
module decade_poll_monitor
  import decade_poll_pkg::*;
#(
  parameter int unsigned RATIO = DEF_RATIO,
  parameter int unsigned TOP_W = DEF_TOP_W,
  localparam int unsigned CW   = $clog2(RATIO)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             poll_i,
  input  logic             clear_i,
  output logic [CW-1:0]    stage0_o,
  output logic [CW-1:0]    stage1_o,
  output logic [CW-1:0]    stage2_o,
  output logic [TOP_W-1:0] stage3_o
);
  logic [NUM_LEVELS-1:0] wrap;
  logic [CW-1:0]         low_val [NUM_LEVELS];

  poll_prescaler #(.RATIO(RATIO), .LEVELS(NUM_LEVELS)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .poll_i  (poll_i),
    .clear_i (clear_i),
    .wrap_o  (wrap)
  );

  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_low
    logic inc;
    if (i == 0) begin : g_first
      assign inc = poll_i & ~clear_i;
    end else begin : g_rest
      assign inc = wrap[i-1];
    end
    poll_stage #(.W(CW), .SAT(1'b0)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc),
      .clr_i  (clear_i | wrap[i]),
      .val_o  (low_val[i])
    );
  end

  poll_stage #(.W(TOP_W), .SAT(1'b1)) u_top (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (wrap[NUM_LEVELS-1]),
    .clr_i  (clear_i),
    .val_o  (stage3_o)
  );

  assign stage0_o = low_val[0];
  assign stage1_o = low_val[1];
  assign stage2_o = low_val[2];

  a_r2_low_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage0_o < CW'(RATIO) && stage1_o < CW'(RATIO) && stage2_o < CW'(RATIO));
  a_r3_decade_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_i && !clear_i && stage0_o == CW'(RATIO - 1)) |=> stage0_o == '0);
  a_r5_thousand_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_i && !clear_i && stage0_o == CW'(RATIO - 1) && stage1_o == CW'(RATIO - 1)
     && stage2_o == CW'(RATIO - 1)) |=> (stage2_o == '0 && stage1_o == '0));
  a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && poll_i) |=> (stage0_o == '0 && stage1_o == '0 && stage2_o == '0
                             && stage3_o == '0));
endmodule

// File: tb/decade_poll_monitor_test.sv
module decade_poll_monitor_test;
  localparam int TOP_W = 4;
  localparam int TOP_MAX = (1 << TOP_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic poll = 1'b0;
  logic clr = 1'b0;
  logic [3:0] s0, s1, s2;
  logic [TOP_W-1:0] s3;

  int checks = 0;
  int errors = 0;
  int pc = 0;
  int m0 = 0, m1 = 0, m2 = 0, m3 = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  decade_poll_monitor #(.RATIO(10), .TOP_W(TOP_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .poll_i(poll), .clear_i(clr),
    .stage0_o(s0), .stage1_o(s1), .stage2_o(s2), .stage3_o(s3)
  );

  task automatic compare(input string tag);
    checks++;
    if (int'(s0) != m0 || int'(s1) != m1 || int'(s2) != m2 || int'(s3) != m3) begin
      errors++;
      $display("FAIL %s: got %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
               tag, s3, s2, s1, s0, m3, m2, m1, m0);
    end
  endtask

  task automatic step(input bit p, input bit c);
    string tag;
    poll = p;
    clr = c;
    if (c) begin
      tag = p ? "R8" : "R7";
      pc = 0; m0 = 0; m1 = 0; m2 = 0; m3 = 0;
    end else if (p) begin
      tag = "R2";
      pc++;
      m0++;
      if (pc % 10 == 0) begin m0 = 0; m1++; tag = "R3"; end
      if (pc % 100 == 0) begin m1 = 0; m2++; tag = "R4"; end
      if (pc % 1000 == 0) begin
        m2 = 0;
        tag = (m3 == TOP_MAX) ? "R6" : "R5";
        if (m3 < TOP_MAX) m3++;
      end
      if (pc == 1000) pc = 0;
    end else begin
      tag = "R2";
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);   // R2 idle
    for (int i = 0; i < 27; i++) step(1'b1, 1'b0);  // R2 R3
    step(1'b1, 1'b1);                               // R8
    for (int i = 0; i < 14; i++) step(1'b1, 1'b0);  // R7 restart
    step(1'b0, 1'b1);                               // R7
    for (int i = 0; i < 2300; i++) step((i % 7) != 3, 1'b0); // R4 R5 with gaps
    step(1'b0, 1'b1);
    for (int i = 0; i < 16250; i++) step(1'b1, 1'b0); // R6 saturation
    step(1'b0, 1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule